// File: doc/BRIEF.md
# Digital Clock Trim Pulse Adjuster

This block sits between a crystal-derived tick stream of about 32.768 kHz and the prescaler of a real-time clock. It corrects the effective timekeeping rate by a signed amount in parts per million. It does this by inserting an extra tick into the stream, or suppressing a tick from it, a few times in every long interval. It does not divide by a fixed ratio.

A 3-bit trim code is written through a strobe. It selects a correction of up to 30 ppm in 10 ppm steps, in either direction. A free-running counter groups raw ticks into intervals of `INTERVAL` ticks, 100,000 by default. In each interval, one correction is made per unit of trim magnitude, so each unit is worth 10 ppm. Raw ticks must be separated by at least two idle system-clock cycles.

Top module: `rtc_tick_trim`

## Requirements
- R1: After reset, `tick_out` is low, the stored trim code is 3'b000, the interval count is zero and no correction is pending. The first interval after reset is therefore uncorrected.
- R2: A raw tick that is not corrected produces a one-cycle `tick_out` strobe on the system-clock cycle right after the cycle in which `tick_in` was high.
- R3: Trim code bit 2 is the direction: 1 adds ticks and 0 skips ticks. Bits 1:0 are the magnitude m, from 0 to 3, in 10 ppm units. Codes 3'b000 and 3'b100 both give no correction.
- R4: In skip direction, each of the first m raw ticks of an interval produces no `tick_out` strobe.
- R5: In add direction, each of the first m raw ticks of an interval keeps its normal strobe. An extra strobe follows one cycle later, two cycles after the raw tick.
- R6: A write (`trim_wr` high) stores `trim_val`. The stored code takes effect only from the interval that begins after the next interval boundary. Corrections already scheduled in the current interval are not changed.
- R7: An interval boundary falls on every `INTERVAL`-th raw tick counted from reset. An interval with magnitude m yields exactly `INTERVAL`+m output strobes in add direction, or `INTERVAL`−m in skip direction. No correction carries into the following interval.
- R8: `tick_out` is high only one or two cycles after a cycle with `tick_in` high. It is never high three cycles after a raw tick unless another raw tick caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Raw tick strobe, one cycle wide |
| trim_wr | input | 1 | Trim code write strobe |
| trim_val | input | 3 | Trim code to store on a write |
| tick_out | output | 1 | Corrected, registered tick strobe |

## Verification
A wrong pending-correction count or a wrong direction flag shows at the ports within two cycles of the next raw tick. It appears as a missing strobe, a surplus strobe or a strobe in the wrong slot. A wrong interval count or a code applied at the wrong time shows as a wrong strobe total over the interval in which it happens. That interval is then checked against `INTERVAL`±m. The bench sweeps every trim code against every write position within a short interval, so an early or late reload is caught in the first interval it affects.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
    localparam int unsigned TRIM_W = 3;
    localparam int unsigned MAG_W  = TRIM_W - 1;

    typedef struct packed {
        logic [TRIM_W-1:0] code;    // stored trim code
        logic [MAG_W-1:0]  pend;    // corrections left in this interval
        logic              add;     // direction of the current interval
        logic              extra;   // extra strobe due next cycle
        logic              out;     // registered output strobe
    } trim_state_t;
endpackage

// File: rtl/rtc_trim_decode.sv
module rtc_trim_decode
    import rtc_trim_pkg::*;
(
    input  logic [TRIM_W-1:0] code,
    output logic [MAG_W-1:0]  mag,
    output logic              add
);
    // top bit selects direction, remaining bits give the magnitude
    assign add = code[TRIM_W-1];
    assign mag = code[MAG_W-1:0];
endmodule

// File: rtl/rtc_trim_interval.sv
module rtc_trim_interval #(
    parameter  int unsigned INTERVAL = 100000,
    localparam int unsigned CW       = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic          wrap,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = tick && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = wrap ? '0 : cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/rtc_tick_trim.sv
module rtc_tick_trim
    import rtc_trim_pkg::*;
#(
    parameter  int unsigned INTERVAL = 100000,
    localparam int unsigned CW       = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              trim_wr,
    input  logic [TRIM_W-1:0] trim_val,
    output logic              tick_out
);
    trim_state_t       s_d, s_q;
    logic              wrap;
    logic [CW-1:0]     cnt_q;
    logic [MAG_W-1:0]  new_mag;
    logic              new_add;
    logic [MAG_W-1:0]  pend_q;
    logic              add_q;

    rtc_trim_interval #(.INTERVAL(INTERVAL)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_in),
        .wrap  (wrap),
        .count (cnt_q)
    );

    rtc_trim_decode u_decode (
        .code (s_q.code),
        .mag  (new_mag),
        .add  (new_add)
    );

    always_comb begin
        s_d       = s_q;
        s_d.extra = 1'b0;
        s_d.out   = s_q.extra;
        if (trim_wr) begin
            s_d.code = trim_val;
        end
        if (tick_in) begin
            if (s_q.pend != '0) begin
                s_d.pend = s_q.pend - MAG_W'(1);
                if (s_q.add) begin
                    s_d.out   = 1'b1;
                    s_d.extra = 1'b1;
                end
            end else begin
                s_d.out = 1'b1;
            end
            if (wrap) begin
                // boundary: schedule the next interval from the stored code
                s_d.pend = new_mag;
                s_d.add  = new_add;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_out = s_q.out;
    assign pend_q   = s_q.pend;
    assign add_q    = s_q.add;
endmodule

// File: rtl/rtc_tick_trim_chk.sv
module rtc_tick_trim_chk
    import rtc_trim_pkg::*;
#(
    parameter  int unsigned INTERVAL = 100000,
    localparam int unsigned CW       = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_in,
    input logic             trim_wr,
    input logic             tick_out,
    input logic [MAG_W-1:0] pend_q,
    input logic             add_q,
    input logic [CW-1:0]    cnt_q
);
    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(INTERVAL - 1));

    // R4
    skip_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && pend_q != '0 && !add_q) |=> !tick_out);

    // R5
    add_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && pend_q != '0 && add_q) |=> tick_out ##1 tick_out);

    // R2
    plain_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_in && pend_q == '0) |=> tick_out);

    // R6
    write_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_wr && !tick_in) |=> $stable(pend_q));

    // R8
    no_stray_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !$past(tick_in)) |=> !tick_out);
endmodule

bind rtc_tick_trim rtc_tick_trim_chk #(.INTERVAL(INTERVAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (tick_in),
    .trim_wr  (trim_wr),
    .tick_out (tick_out),
    .pend_q   (pend_q),
    .add_q    (add_q),
    .cnt_q    (cnt_q)
);

// File: tb/test_rtc_tick_trim.sv
module test_rtc_tick_trim;
    localparam int unsigned I = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_in = 1'b0;
    logic       trim_wr = 1'b0;
    logic [2:0] trim_val = '0;
    logic       tick_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    int k = 0;
    int m_pend = 0;
    bit m_add = 0;
    int m_code = 0;
    int iv_mag = 0;
    bit iv_add = 0;
    int iv_cnt = 0;

    always #5 clk = ~clk;

    rtc_tick_trim #(.INTERVAL(I)) i_rtc_tick_trim (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in),
        .trim_wr(trim_wr), .trim_val(trim_val), .tick_out(tick_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        k = 0; m_pend = 0; m_add = 0; m_code = 0;
        iv_mag = 0; iv_add = 0; iv_cnt = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_in = 1'b0; trim_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 tick_out low in reset", int'(tick_out), 0);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check("R1 tick_out low after reset", int'(tick_out), 0);
    endtask

    task automatic write_trim(input int code);
        @(negedge clk);
        trim_wr = 1'b1; trim_val = 3'(code);
        @(negedge clk);
        trim_wr = 1'b0;
        m_code = code;
    endtask

    task automatic raw_tick();
        logic o1, o2, o3;
        int e1, e2, tot;
        string req;
        e1 = (m_pend > 0 && !m_add) ? 0 : 1;
        e2 = (m_pend > 0 && m_add) ? 1 : 0;
        req = (m_pend == 0) ? "R2 R8 plain tick" :
              (m_add ? "R5 R8 add tick" : "R4 R8 skip tick");
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk); tick_in = 1'b0; o1 = tick_out;
        @(negedge clk); o2 = tick_out;
        @(negedge clk); o3 = tick_out;
        check(req, int'({o1, o2, o3}), (e1 << 2) | (e2 << 1));
        iv_cnt += int'(o1) + int'(o2);
        if (m_pend > 0) m_pend--;
        if (k % I == I - 1) begin
            tot = iv_add ? I + iv_mag : I - iv_mag;
            check("R3 R6 R7 interval strobe total", iv_cnt, tot);
            iv_cnt = 0;
            m_pend = m_code & 3;
            m_add  = (m_code >> 2) & 1;
            iv_mag = m_pend;
            iv_add = m_add;
        end
        k++;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1: first interval after reset is uncorrected
        repeat (I) raw_tick();
        // R3 R6 R7: every code against every write position
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < int'(I); p++) begin
                while (k % I != p) raw_tick();
                write_trim(code);
                repeat (2 * I) raw_tick();
            end
        end
        // R6: two writes in one interval, the last one wins
        while (k % I != 2) raw_tick();
        write_trim(3'b111);
        raw_tick();
        write_trim(3'b001);
        repeat (2 * I) raw_tick();
        // R1: reset clears the stored code
        write_trim(3'b011);
        do_reset();
        repeat (2 * I) raw_tick();
        finish_run();
    end
endmodule